// File: doc/BRIEF.md
# Data-Space Address Generator and Region Decoder

This block forms the effective data-space address of each load or store and routes the access to one of four regions: the working registers, the short-reach I/O window, the extended I/O window or internal SRAM. The address comes from a direct 16-bit operand, from a 6-bit short I/O offset, or from one of three 16-bit pointers. Each pointer is held as a byte pair inside the block's own model of the 32 working registers. The pointer can be used as it is, with an unsigned displacement added, decremented before use, or incremented after use. When a pointer changes, the block writes the new value back into its register pair.

An access starts with a one-cycle `start` strobe. One cycle later the block presents the address, a one-hot region select, the offset inside that region, a write strobe and two error flags. Register-file and I/O accesses finish in that same cycle. An SRAM access holds `busy` for two cycles and then pulses `done` for one cycle. Stores that hit the register region write the internal register model. Loads from that region return the old register value on `rf_rdata`. Because of this, the pointers can be set and read back through ordinary accesses.

Top module: `dspace_agu`

## Requirements
- R1: An address below 0x0020 selects the register region (region bit 0). An address from 0x0020 to 0x005F selects standard I/O (bit 1). An address from 0x0060 to 0x00FF selects extended I/O (bit 2). An address from 0x0100 to 0x02FF selects SRAM (bit 3). `local_off` is the address minus the base of its region. At most one region bit is ever set.
- R2: Mode 0 (direct) uses `dir_addr` unchanged as the address, for any 16-bit value.
- R3: Mode 1 (indirect) uses the selected pointer as the address. `ptr_sel` 0, 1 and 2 select X, Y and Z. These pointers live in registers 26/27, 28/29 and 30/31, with the low byte in the even register.
- R4: Mode 2 (displacement) adds the zero-extended `disp` (0..63) to Y or Z, modulo 2^16. A mode error is raised, with no region, no write and no pointer change, in these cases: mode 2 with X, any pointer mode (1..4) with `ptr_sel` 3, and modes 6 and 7.
- R5: Mode 3 (pre-decrement) uses the pointer minus 1 as the address and writes that value back to the pointer pair.
- R6: Mode 4 (post-increment) uses the old pointer as the address and writes the pointer plus 1 back to the pair.
- R7: Mode 5 (short I/O) uses 0x0020 + `disp` as the address and leaves all pointers unchanged.
- R8: An address above 0x02FF raises `range_err`. It selects no region, gives `local_off` 0, produces no `wr_strobe`, writes no register and does no pointer write-back. It completes in one cycle.
- R9: A store to the register region writes `wdata` into that register. A load from it returns the register's value from before the access on `rf_rdata`. If a store and a pointer write-back hit the same register, the write-back wins.
- R10: `acc_valid` pulses one cycle after an accepted `start`. Non-SRAM accesses and errors pulse `done` in that same cycle. An SRAM access keeps `busy` high for two cycles, then pulses `done` for one cycle. A `start` seen while `busy` is high is ignored. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Access request strobe |
| mode | input | 3 | Addressing mode (0..5 valid) |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Displacement or short I/O offset |
| dir_addr | input | 16 | Direct address operand |
| is_write | input | 1 | 1 for store, 0 for load |
| wdata | input | 8 | Store data for register-region writes |
| acc_valid | output | 1 | Access outputs valid this cycle |
| eff_addr | output | 16 | Effective data-space address |
| region | output | 4 | One-hot region select |
| local_off | output | 16 | Offset inside the selected region |
| wr_strobe | output | 1 | Store accepted to a legal address |
| range_err | output | 1 | Address above top of SRAM |
| mode_err | output | 1 | Illegal mode/pointer combination |
| busy | output | 1 | SRAM access in progress |
| done | output | 1 | Access completed |
| rf_rdata | output | 8 | Register value read by a register-region load |

## Verification
Direct accesses are placed on each side of every region boundary, including the last SRAM byte and the first byte past it. This separates correct region decode and offset arithmetic from off-by-one errors. Each pointer mode is run against pointers loaded through register-region stores and then read back with direct loads. This tells pre-decrement from post-increment, shows whether write-back happens at all, and checks the byte order inside the register pair. Displacement from Z at 0xFFFF checks wrap-around. Displacement with X and a reserved mode check the mode-error path. A store through post-increment onto the pointer's own register shows which write wins. A `start` held high through an SRAM access shows that requests are dropped while busy.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    localparam int AW = 16;

    typedef logic [AW-1:0] daddr_t;

    typedef enum logic [2:0] {
        AM_DIRECT  = 3'd0,
        AM_IND     = 3'd1,
        AM_DISP    = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4,
        AM_IOSHORT = 3'd5,
        AM_RSV6    = 3'd6,
        AM_RSV7    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        PS_X    = 2'd0,
        PS_Y    = 2'd1,
        PS_Z    = 2'd2,
        PS_NONE = 2'd3
    } psel_e;

    localparam int RGN_RF   = 0;
    localparam int RGN_IO   = 1;
    localparam int RGN_XIO  = 2;
    localparam int RGN_SRAM = 3;
    localparam int RGN_N    = 4;

    typedef struct packed {
        daddr_t      addr;
        logic        merr;
        logic        upd;
        logic [1:0]  upd_sel;
        daddr_t      new_ptr;
    } ea_t;

    function automatic logic needs_ptr(amode_e m);
        return (m == AM_IND) || (m == AM_DISP) || (m == AM_PREDEC) || (m == AM_POSTINC);
    endfunction

endpackage

// File: rtl/dspace_regfile.sv
module dspace_regfile
    import dspace_pkg::*;
#(
    parameter int NREGS = 32,
    parameter int DW    = 8,
    localparam int IW    = $clog2(NREGS),
    localparam int PBASE = NREGS - 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_en,
    input  logic [IW-1:0]         st_idx,
    input  logic [DW-1:0]         st_data,
    input  logic                  wb_en,
    input  logic [1:0]            wb_sel,
    input  daddr_t                wb_val,
    input  logic [IW-1:0]         rd_idx,
    output logic [DW-1:0]         rd_data,
    output logic [2:0][AW-1:0]    ptrs
);

    logic [DW-1:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g >= PBASE) begin : g_ptr_byte
            localparam int PI = (g - PBASE) / 2;
            localparam bit HI = ((g - PBASE) % 2) == 1;
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[g] <= '0;
                end else begin
                    if (st_en && st_idx == IW'(g))
                        regs[g] <= st_data;
                    if (wb_en && wb_sel == 2'(PI))
                        regs[g] <= HI ? wb_val[15:8] : wb_val[7:0];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (st_en && st_idx == IW'(g))
                    regs[g] <= st_data;
            end
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_ptr
        assign ptrs[k] = {regs[PBASE + 2*k + 1], regs[PBASE + 2*k]};
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/dspace_ea.sv
module dspace_ea
    import dspace_pkg::*;
#(
    parameter int DISP_W  = 6,
    parameter int IO_BASE = 32
) (
    input  amode_e              mode,
    input  logic [1:0]          sel,
    input  logic [DISP_W-1:0]   disp,
    input  daddr_t              dir_addr,
    input  logic [2:0][AW-1:0]  ptrs,
    output ea_t                 ea
);

    daddr_t base;
    logic   sel_ok;
    logic   yz_ok;

    always_comb begin
        case (sel)
            PS_X:    base = ptrs[0];
            PS_Y:    base = ptrs[1];
            PS_Z:    base = ptrs[2];
            default: base = '0;
        endcase
    end

    assign sel_ok = (sel != PS_NONE);
    assign yz_ok  = (sel == PS_Y) || (sel == PS_Z);

    always_comb begin
        ea         = '0;
        ea.upd_sel = sel;
        case (mode)
            AM_DIRECT: ea.addr = dir_addr;
            AM_IND:    ea.addr = base;
            AM_DISP: begin
                ea.addr = base + AW'(disp);
                ea.merr = !yz_ok;
            end
            AM_PREDEC: begin
                ea.addr    = base - AW'(1);
                ea.new_ptr = base - AW'(1);
                ea.upd     = 1'b1;
            end
            AM_POSTINC: begin
                ea.addr    = base;
                ea.new_ptr = base + AW'(1);
                ea.upd     = 1'b1;
            end
            AM_IOSHORT: ea.addr = AW'(IO_BASE) + AW'(disp);
            default:    ea.merr = 1'b1;
        endcase
        if (needs_ptr(mode) && !sel_ok)
            ea.merr = 1'b1;
        if (ea.merr)
            ea.upd = 1'b0;
    end

endmodule

// File: rtl/dspace_region.sv
module dspace_region
    import dspace_pkg::*;
#(
    parameter int NREGS      = 32,
    parameter int IO_SIZE    = 64,
    parameter int XIO_SIZE   = 160,
    parameter int SRAM_BYTES = 512,
    localparam int IO_BASE   = NREGS,
    localparam int XIO_BASE  = IO_BASE + IO_SIZE,
    localparam int SRAM_BASE = XIO_BASE + XIO_SIZE,
    localparam int SRAM_TOP  = SRAM_BASE + SRAM_BYTES - 1
) (
    input  daddr_t            addr,
    output logic [RGN_N-1:0]  rgn,
    output daddr_t            off,
    output logic              oor
);

    always_comb begin
        rgn = '0;
        off = '0;
        oor = 1'b0;
        if (addr < AW'(IO_BASE)) begin
            rgn[RGN_RF] = 1'b1;
            off         = addr;
        end else if (addr < AW'(XIO_BASE)) begin
            rgn[RGN_IO] = 1'b1;
            off         = addr - AW'(IO_BASE);
        end else if (addr < AW'(SRAM_BASE)) begin
            rgn[RGN_XIO] = 1'b1;
            off          = addr - AW'(XIO_BASE);
        end else if (addr <= AW'(SRAM_TOP)) begin
            rgn[RGN_SRAM] = 1'b1;
            off           = addr - AW'(SRAM_BASE);
        end else begin
            oor = 1'b1;
        end
    end

endmodule

// File: rtl/dspace_seq.sv
module dspace_seq #(
    parameter int SRAM_CYCLES = 2,
    localparam int CW = $clog2(SRAM_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_slow,
    input  logic launch_fast,
    output logic busy,
    output logic done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            if (launch_slow)
                cnt <= CW'(SRAM_CYCLES);
            else if (cnt != '0)
                cnt <= cnt - CW'(1);
            done <= launch_fast || (cnt == CW'(1));
        end
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/dspace_agu.sv
module dspace_agu
    import dspace_pkg::*;
#(
    parameter int NREGS       = 32,
    parameter int IO_SIZE     = 64,
    parameter int XIO_SIZE    = 160,
    parameter int SRAM_BYTES  = 512,
    parameter int DISP_W      = 6,
    parameter int DW          = 8,
    parameter int SRAM_CYCLES = 2,
    localparam int IW         = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [1:0]        ptr_sel,
    input  logic [DISP_W-1:0] disp,
    input  logic [AW-1:0]     dir_addr,
    input  logic              is_write,
    input  logic [DW-1:0]     wdata,
    output logic              acc_valid,
    output logic [AW-1:0]     eff_addr,
    output logic [RGN_N-1:0]  region,
    output logic [AW-1:0]     local_off,
    output logic              wr_strobe,
    output logic              range_err,
    output logic              mode_err,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rf_rdata
);

    logic               accept;
    logic               good;
    ea_t                ea;
    logic [RGN_N-1:0]   rgn;
    daddr_t             off;
    logic               oor;
    logic [2:0][AW-1:0] ptrs;
    logic [DW-1:0]      rd_data;
    logic               to_sram;

    assign accept  = start && !busy;
    assign good    = accept && !ea.merr && !oor;
    assign to_sram = good && rgn[RGN_SRAM];

    dspace_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .st_en   (good && is_write && rgn[RGN_RF]),
        .st_idx  (ea.addr[IW-1:0]),
        .st_data (wdata),
        .wb_en   (good && ea.upd),
        .wb_sel  (ea.upd_sel),
        .wb_val  (ea.new_ptr),
        .rd_idx  (ea.addr[IW-1:0]),
        .rd_data (rd_data),
        .ptrs    (ptrs)
    );

    dspace_ea #(.DISP_W(DISP_W), .IO_BASE(NREGS)) u_ea (
        .mode     (amode_e'(mode)),
        .sel      (ptr_sel),
        .disp     (disp),
        .dir_addr (dir_addr),
        .ptrs     (ptrs),
        .ea       (ea)
    );

    dspace_region #(
        .NREGS(NREGS), .IO_SIZE(IO_SIZE), .XIO_SIZE(XIO_SIZE), .SRAM_BYTES(SRAM_BYTES)
    ) u_rgn (
        .addr (ea.addr),
        .rgn  (rgn),
        .off  (off),
        .oor  (oor)
    );

    dspace_seq #(.SRAM_CYCLES(SRAM_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch_slow (to_sram),
        .launch_fast (accept && !to_sram),
        .busy        (busy),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid <= 1'b0;
            eff_addr  <= '0;
            region    <= '0;
            local_off <= '0;
            wr_strobe <= 1'b0;
            range_err <= 1'b0;
            mode_err  <= 1'b0;
            rf_rdata  <= '0;
        end else begin
            acc_valid <= accept;
            region    <= (accept && !ea.merr) ? rgn : '0;
            wr_strobe <= good && is_write;
            range_err <= accept && !ea.merr && oor;
            mode_err  <= accept && ea.merr;
            if (accept && !ea.merr) begin
                eff_addr  <= ea.addr;
                local_off <= off;
            end
            if (good && !is_write && rgn[RGN_RF])
                rf_rdata <= rd_data;
        end
    end

endmodule

// File: rtl/dspace_agu_chk.sv
module dspace_agu_chk #(
    parameter logic [15:0] SRAM_TOP = 16'h02FF
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        acc_valid,
    input logic [15:0] eff_addr,
    input logic [3:0]  region,
    input logic        wr_strobe,
    input logic        range_err,
    input logic        mode_err,
    input logic        busy,
    input logic        done
);

    // R1
    rgn_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region));

    // R1
    rgn_present_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !range_err && !mode_err) |-> ($countones(region) == 1));

    // R8
    oor_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        range_err |-> (!wr_strobe && region == 4'b0000));

    // R8
    oor_addr_chk: assert property (@(posedge clk) disable iff (rst)
        range_err |-> (eff_addr > SRAM_TOP));

    // R4
    merr_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (!wr_strobe && region == 4'b0000));

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R10
    sram_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !acc_valid);

    // R10
    sram_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && region[3]) |-> busy);

endmodule

bind dspace_agu dspace_agu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .acc_valid (acc_valid),
    .eff_addr  (eff_addr),
    .region    (region),
    .wr_strobe (wr_strobe),
    .range_err (range_err),
    .mode_err  (mode_err),
    .busy      (busy),
    .done      (done)
);

// File: tb/dspace_agu_bench.sv
module dspace_agu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic [5:0]  disp = '0;
    logic [15:0] dir_addr = '0;
    logic        is_write = 1'b0;
    logic [7:0]  wdata = '0;
    logic        acc_valid;
    logic [15:0] eff_addr;
    logic [3:0]  region;
    logic [15:0] local_off;
    logic        wr_strobe;
    logic        range_err;
    logic        mode_err;
    logic        busy;
    logic        done;
    logic [7:0]  rf_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R10";

    // reference model state
    int rf [32];
    int cnt = 0;
    int e_valid = 0, e_addr = 0, e_rgn = 0, e_off = 0, e_we = 0;
    int e_rerr = 0, e_merr = 0, e_done = 0, e_rdata = 0;

    always #5 clk = ~clk;

    dspace_agu u_dspace_agu (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .ptr_sel(ptr_sel),
        .disp(disp), .dir_addr(dir_addr), .is_write(is_write), .wdata(wdata),
        .acc_valid(acc_valid), .eff_addr(eff_addr), .region(region),
        .local_off(local_off), .wr_strobe(wr_strobe), .range_err(range_err),
        .mode_err(mode_err), .busy(busy), .done(done), .rf_rdata(rf_rdata)
    );

    always @(posedge clk) begin
        int  ptr, a, np, rg, of;
        bit  me, up, busy_old;
        if (rst) begin
            for (int i = 0; i < 32; i++) rf[i] = 0;
            cnt = 0; e_valid = 0; e_addr = 0; e_rgn = 0; e_off = 0; e_we = 0;
            e_rerr = 0; e_merr = 0; e_done = 0; e_rdata = 0;
        end else begin
            busy_old = (cnt != 0);
            e_done = 0;
            if (cnt > 0) begin
                if (cnt == 1) e_done = 1;
                cnt--;
            end
            e_valid = 0; e_we = 0; e_rerr = 0; e_merr = 0; e_rgn = 0;
            if (start && !busy_old) begin
                e_valid = 1;
                ptr = (ptr_sel < 3) ? rf[26 + 2*ptr_sel] + 256 * rf[27 + 2*ptr_sel] : 0;
                me = 0; up = 0; np = 0; a = 0;
                case (mode)
                    0: a = dir_addr;
                    1: begin a = ptr; me = (ptr_sel == 3); end
                    2: begin a = (ptr + disp) % 65536; me = !(ptr_sel == 1 || ptr_sel == 2); end
                    3: begin a = (ptr + 65535) % 65536; np = a; up = 1; me = (ptr_sel == 3); end
                    4: begin a = ptr; np = (ptr + 1) % 65536; up = 1; me = (ptr_sel == 3); end
                    5: a = 32 + disp;
                    default: me = 1;
                endcase
                if (me) begin
                    e_merr = 1;
                    e_done = 1;
                end else begin
                    if (a < 32) begin rg = 1; of = a; end
                    else if (a < 96) begin rg = 2; of = a - 32; end
                    else if (a < 256) begin rg = 4; of = a - 96; end
                    else if (a <= 'h2FF) begin rg = 8; of = a - 256; end
                    else begin rg = 0; of = 0; end
                    e_addr = a; e_off = of; e_rgn = rg;
                    if (rg == 0) begin
                        e_rerr = 1;
                    end else begin
                        if (rg == 1 && !is_write) e_rdata = rf[a];
                        if (rg == 1 && is_write) rf[a] = wdata;
                        if (up) begin
                            rf[26 + 2*ptr_sel] = np % 256;
                            rf[27 + 2*ptr_sel] = np / 256;
                        end
                        e_we = is_write;
                    end
                    if (rg == 8) cnt = 2; else e_done = 1;
                end
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp("acc_valid", int'(acc_valid), e_valid);
            cmp("eff_addr",  int'(eff_addr),  e_addr);
            cmp("region",    int'(region),    e_rgn);
            cmp("local_off", int'(local_off), e_off);
            cmp("wr_strobe", int'(wr_strobe), e_we);
            cmp("range_err", int'(range_err), e_rerr);
            cmp("mode_err",  int'(mode_err),  e_merr);
            cmp("busy",      int'(busy),      int'(cnt != 0));
            cmp("done",      int'(done),      e_done);
            cmp("rf_rdata",  int'(rf_rdata),  e_rdata);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic acc(input int m, input int s, input int d, input int a,
                       input int w, input int wd, input string req);
        @(negedge clk);
        cur_req = req;
        mode = 3'(m); ptr_sel = 2'(s); disp = 6'(d); dir_addr = 16'(a);
        is_write = w[0]; wdata = 8'(wd); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);   // R10 reset state compared here
        // R9: set pointers through register-region stores
        acc(0, 0, 0, 26, 1, 'h10, "R9");
        acc(0, 0, 0, 27, 1, 'h01, "R9");
        acc(0, 0, 0, 28, 1, 'hFF, "R9");
        acc(0, 0, 0, 29, 1, 'h00, "R9");
        acc(0, 0, 0, 30, 1, 'hFF, "R9");
        acc(0, 0, 0, 31, 1, 'hFF, "R9");
        acc(0, 0, 0, 26, 0, 0, "R9");
        // R1 / R2: region boundaries by direct address
        acc(0, 0, 0, 'h001F, 0, 0, "R1");
        acc(0, 0, 0, 'h0020, 1, 1, "R1");
        acc(0, 0, 0, 'h005F, 0, 0, "R1");
        acc(0, 0, 0, 'h0060, 0, 0, "R1");
        acc(0, 0, 0, 'h00FF, 1, 2, "R1");
        acc(0, 0, 0, 'h0100, 0, 0, "R2");
        acc(0, 0, 0, 'h02FF, 1, 3, "R2");
        // R8: just past SRAM, with and without store
        acc(0, 0, 0, 'h0300, 1, 4, "R8");
        acc(0, 0, 0, 'hFFFF, 0, 0, "R8");
        // R3: indirect from X, Y, Z
        acc(1, 0, 0, 0, 0, 0, "R3");
        acc(1, 1, 0, 0, 1, 5, "R3");
        acc(1, 2, 0, 0, 0, 0, "R3");
        // R4: displacement, wrap, illegal combinations
        acc(2, 1, 63, 0, 0, 0, "R4");
        acc(2, 2, 1, 0, 0, 0, "R4");
        acc(2, 0, 4, 0, 1, 6, "R4");
        acc(1, 3, 0, 0, 0, 0, "R4");
        acc(7, 0, 0, 0, 1, 7, "R4");
        // R5: pre-decrement Y, then read back its low byte
        acc(3, 1, 0, 0, 0, 0, "R5");
        acc(0, 0, 0, 28, 0, 0, "R5");
        // R8: post-increment Z at 0xFFFF is out of range, no write-back
        acc(4, 2, 0, 0, 0, 0, "R8");
        acc(0, 0, 0, 30, 0, 0, "R8");
        // R6: post-increment X, then read back
        acc(4, 0, 0, 0, 0, 0, "R6");
        acc(0, 0, 0, 26, 0, 0, "R6");
        // R7: short I/O mode
        acc(5, 0, 5, 0, 1, 8, "R7");
        acc(5, 0, 63, 0, 0, 0, "R7");
        // R9: store through post-increment onto X's own low byte
        acc(0, 0, 0, 26, 1, 'h1A, "R9");
        acc(0, 0, 0, 27, 1, 'h00, "R9");
        acc(4, 0, 0, 0, 1, 'hAA, "R9");
        acc(0, 0, 0, 26, 0, 0, "R9");
        acc(0, 0, 0, 27, 0, 0, "R9");
        // R10: start held through an SRAM access
        @(negedge clk);
        cur_req = "R10";
        mode = 3'd0; dir_addr = 16'h0200; is_write = 1'b0; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule